// File: doc/BRIEF.md
# Audio Link Control-Enable Register

This block holds the mode bits that steer the serial audio link between a host and up to two codecs. Software turns a mode on by writing a 1 to its position through the enable port, and turns it off by writing a 1 through a separate disable port. In both ports a written 0 leaves the bit as it was. The stored bits drive the link pins directly:
- the active-low codec reset;
- a warm-reset request that holds the frame sync line high;
- a low-power mode that ties the sync and serial-out lines low;
- the choice of receive slot.

The block also keeps one ready flag per codec. The frame receiver sets a flag with a one-cycle pulse. Software clears both flags by writing a 1 to a strobe position of the enable port, for instance after it has sent a codec a power-down command. When wake-up is enabled and any serial data input from a codec is high, a power-management wake request goes out to the interrupt controller.

The frame serializer, slot timing and the codecs are outside the block. The frame logic's own sync and serial-out levels come in, and the gated versions go out to the pins.

Top module: `aclink_ctl_reg`

## Requirements
- R1: After reset every mode bit and both codec-ready flags are 0, `rd_data` reads 0x00 and `link_reset_n` is 0.
- R2: A cycle with `set_we` high sets each mode bit whose position holds a 1 in `set_wdata`, from the next clock edge on. Bit positions are: 0 link enable, 1 low-power, 2 wake-up enable, 3 warm reset, 4 microphone select. `rd_data` returns these bits in the same positions, and bits 7:5 always read 0.
- R3: A 0 written through either port leaves the corresponding mode bit unchanged. Bits 7:6 of `set_wdata` have no effect.
- R4: A cycle with `clr_we` high clears each mode bit whose position (4:0) holds a 1 in `clr_wdata`. If set and clear hit the same bit in the same cycle, the bit ends up 0.
- R5: `set_we` with bit 5 of `set_wdata` at 1 clears both codec-ready flags at the next edge. Bit 5 is never stored and reads 0, and bit 5 of `clr_wdata` has no effect.
- R6: A pulse on `ready_pulse[i]` sets `codec_ready[i]` at the next edge. A clear strobe in the same cycle wins, leaving the flag 0.
- R7: `link_reset_n` is 0 while the link-enable bit is 0, and 1 while it is 1.
- R8: While the low-power bit is 1, `link_sdout` is 0. `link_sync` is also 0 unless warm reset is set. With both bits 0, the pins follow `frame_sync` and `frame_sdout`.
- R9: While the warm-reset bit is 1, `link_sync` is 1, overriding both the frame sync and low-power. The warm-reset bit does not alter `link_sdout`.
- R10: `wake_irq` is 1 exactly when the wake-up enable bit is 1 and at least one bit of `sdin` is 1.
- R11: `rx_mic_sel` equals the microphone-select bit: 0 selects PCM left/right slots 3 and 4, 1 selects microphone slot 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_we | input | 1 | Enable-port write strobe |
| set_wdata | input | 8 | Enable-port data: a 1 sets a mode bit; bit 5 clears the ready flags |
| clr_we | input | 1 | Disable-port write strobe |
| clr_wdata | input | 8 | Disable-port data: a 1 clears a mode bit |
| rd_data | output | 8 | Register read-back |
| ready_pulse | input | 2 | Per-codec ready pulse from the frame receiver |
| codec_ready | output | 2 | Per-codec ready flags |
| frame_sync | input | 1 | Sync level from the frame logic |
| frame_sdout | input | 1 | Serial-out level from the frame logic |
| sdin | input | 2 | Serial data inputs from the codecs |
| link_sync | output | 1 | Gated sync pin |
| link_sdout | output | 1 | Gated serial-out pin |
| link_reset_n | output | 1 | Active-low codec reset |
| rx_mic_sel | output | 1 | Receive slot select |
| wake_irq | output | 1 | Wake interrupt request |

## Verification
Two pairs of functions can land in the same cycle. In the first, a set and a clear of the same mode bit arrive together, with both ports strobed on one edge. In the second, a codec ready pulse arrives in the very cycle that software strobes the ready-flag clear. The bench provokes both, and the expected result is that the clear wins in each case, which is judged from `rd_data` and `codec_ready` one edge later. The bench also overlaps warm reset with low-power to check which of them wins on the sync pin.

// File: rtl/aclink_ctl_pkg.sv
package aclink_ctl_pkg;
    localparam int REG_W      = 8;
    localparam int MODE_W     = 5;
    localparam int RDYCLR_BIT = 5;

    typedef struct packed {
        logic mic;     // bit 4
        logic warm;    // bit 3
        logic wake;    // bit 2
        logic lowpwr;  // bit 1
        logic enable;  // bit 0
    } mode_t;
endpackage

// File: rtl/aclink_mode_bits.sv
module aclink_mode_bits #(
    parameter int MODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [MODE_W-1:0] set_bits,
    input  logic              clr_we,
    input  logic [MODE_W-1:0] clr_bits,
    output logic [MODE_W-1:0] bits_q
);
    typedef struct packed {
        logic [MODE_W-1:0] bits;
    } st_t;

    st_t st_d, st_q;
    logic [MODE_W-1:0] set_m, clr_m;

    assign set_m = set_we ? set_bits : '0;
    assign clr_m = clr_we ? clr_bits : '0;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MODE_W; i++) begin
            if (clr_m[i])      st_d.bits[i] = 1'b0;
            else if (set_m[i]) st_d.bits[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;

    for (genvar g = 0; g < MODE_W; g++) begin : g_chk
        // R2: a written 1 with no clear sets the bit
        a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (set_we && set_bits[g] && !(clr_we && clr_bits[g])) |=> bits_q[g]);
        // R4: a clear always leaves the bit 0, even against a set
        a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[g]) |=> !bits_q[g]);
        // R3: zeros on both ports leave the bit unchanged
        a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!(set_we && set_bits[g]) && !(clr_we && clr_bits[g])) |=> $stable(bits_q[g]));
    end
endmodule

// File: rtl/aclink_ready_flags.sv
module aclink_ready_flags #(
    parameter int N_CODEC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CODEC-1:0] ready_pulse,
    input  logic               clr_req,
    output logic [N_CODEC-1:0] ready_q
);
    typedef struct packed {
        logic [N_CODEC-1:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.flags = st_q.flags | ready_pulse;
        if (clr_req) st_d.flags = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_q = st_q.flags;

    // R5/R6: the clear strobe empties every flag, even against a pulse
    a_r6_clear_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (ready_q == '0));

    for (genvar g = 0; g < N_CODEC; g++) begin : g_chk
        a_r6_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (ready_pulse[g] && !clr_req) |=> ready_q[g]);
        a_r6_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            (ready_q[g] && !clr_req) |=> ready_q[g]);
    end
endmodule

// File: rtl/aclink_pin_gate.sv
module aclink_pin_gate
    import aclink_ctl_pkg::*;
#(
    parameter int N_SDIN = 2
) (
    input  mode_t             mode,
    input  logic              frame_sync,
    input  logic              frame_sdout,
    input  logic [N_SDIN-1:0] sdin,
    output logic              link_sync,
    output logic              link_sdout,
    output logic              link_reset_n,
    output logic              rx_mic_sel,
    output logic              wake_irq
);
    always_comb begin
        if (mode.warm)        link_sync = 1'b1;
        else if (mode.lowpwr) link_sync = 1'b0;
        else                  link_sync = frame_sync;
        link_sdout   = mode.lowpwr ? 1'b0 : frame_sdout;
        link_reset_n = mode.enable;
        rx_mic_sel   = mode.mic;
        wake_irq     = mode.wake && (|sdin);
    end
endmodule

// File: rtl/aclink_ctl_reg.sv
module aclink_ctl_reg
    import aclink_ctl_pkg::*;
#(
    parameter int N_CODEC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic [REG_W-1:0]   set_wdata,
    input  logic               clr_we,
    input  logic [REG_W-1:0]   clr_wdata,
    output logic [REG_W-1:0]   rd_data,
    input  logic [N_CODEC-1:0] ready_pulse,
    output logic [N_CODEC-1:0] codec_ready,
    input  logic               frame_sync,
    input  logic               frame_sdout,
    input  logic [N_CODEC-1:0] sdin,
    output logic               link_sync,
    output logic               link_sdout,
    output logic               link_reset_n,
    output logic               rx_mic_sel,
    output logic               wake_irq
);
    localparam int PAD_W = REG_W - MODE_W;

    logic [MODE_W-1:0] mode_bits;
    mode_t             mode_q;
    logic              rdy_clr;

    assign rdy_clr = set_we && set_wdata[RDYCLR_BIT];

    aclink_mode_bits #(.MODE_W(MODE_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we),
        .set_bits (set_wdata[MODE_W-1:0]),
        .clr_we   (clr_we),
        .clr_bits (clr_wdata[MODE_W-1:0]),
        .bits_q   (mode_bits)
    );

    assign mode_q  = mode_t'(mode_bits);
    assign rd_data = {{PAD_W{1'b0}}, mode_bits};

    aclink_ready_flags #(.N_CODEC(N_CODEC)) u_ready (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_pulse (ready_pulse),
        .clr_req     (rdy_clr),
        .ready_q     (codec_ready)
    );

    aclink_pin_gate #(.N_SDIN(N_CODEC)) u_gate (
        .mode         (mode_q),
        .frame_sync   (frame_sync),
        .frame_sdout  (frame_sdout),
        .sdin         (sdin),
        .link_sync    (link_sync),
        .link_sdout   (link_sdout),
        .link_reset_n (link_reset_n),
        .rx_mic_sel   (rx_mic_sel),
        .wake_irq     (wake_irq)
    );

    // R7: codec reset follows the stored enable bit
    a_r7_reset_follows: assert property (@(posedge clk) disable iff (!rst_n)
        link_reset_n == mode_q.enable);
    // R9: warm reset holds sync high
    a_r9_warm_sync: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.warm |-> link_sync);
    // R8: low-power without warm reset ties both pins low
    a_r8_lowpwr_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.lowpwr && !mode_q.warm) |-> (!link_sync && !link_sdout));
    // R10: no wake request without the enable
    a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (mode_q.wake && (sdin != '0)));
    // R5: read-back bits above the mode field stay 0, including bit 5
    a_r5_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:MODE_W] == '0);
endmodule

// File: tb/aclink_ctl_reg_tb.sv
module aclink_ctl_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_we = 1'b0, clr_we = 1'b0;
    logic [7:0] set_wdata = '0, clr_wdata = '0, rd_data;
    logic [1:0] ready_pulse = '0, codec_ready, sdin = '0;
    logic       frame_sync = 1'b0, frame_sdout = 1'b0;
    logic       link_sync, link_sdout, link_reset_n, rx_mic_sel, wake_irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    aclink_ctl_reg dut_i (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_wdata(set_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .rd_data(rd_data),
        .ready_pulse(ready_pulse), .codec_ready(codec_ready),
        .frame_sync(frame_sync), .frame_sdout(frame_sdout), .sdin(sdin),
        .link_sync(link_sync), .link_sdout(link_sdout),
        .link_reset_n(link_reset_n), .rx_mic_sel(rx_mic_sel), .wake_irq(wake_irq)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic [1:0] rdy;
        logic       sync, sdout, rstn, mic, irq;
    } exp_t;

    exp_t       sb_q[$];
    logic [4:0] m_mode = '0;
    logic [1:0] m_rdy  = '0;

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, model its effect, queue expectation
    task automatic step(string tag, logic sw, logic [7:0] sd, logic cw, logic [7:0] cd,
                        logic [1:0] pulse, logic fs, logic fo, logic [1:0] si);
        exp_t e;
        @(negedge clk);
        set_we = sw; set_wdata = sd; clr_we = cw; clr_wdata = cd;
        ready_pulse = pulse; frame_sync = fs; frame_sdout = fo; sdin = si;
        m_mode = (m_mode | (sw ? sd[4:0] : 5'b0)) & ~(cw ? cd[4:0] : 5'b0);
        m_rdy  = (m_rdy | pulse) & ~((sw && sd[5]) ? 2'b11 : 2'b00);
        e.tag   = tag;
        e.rd    = {3'b000, m_mode};
        e.rdy   = m_rdy;
        e.sync  = m_mode[3] ? 1'b1 : (m_mode[1] ? 1'b0 : fs);
        e.sdout = m_mode[1] ? 1'b0 : fo;
        e.rstn  = m_mode[0];
        e.mic   = m_mode[4];
        e.irq   = m_mode[2] && (si != 2'b00);
        sb_q.push_back(e);
    endtask

    // monitor: sample shortly after each edge and compare with the queue head
    always begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "rd_data",      rd_data,              e.rd);
            check(e.tag, "codec_ready",  {6'b0, codec_ready},  {6'b0, e.rdy});
            check(e.tag, "link_sync",    {7'b0, link_sync},    {7'b0, e.sync});
            check(e.tag, "link_sdout",   {7'b0, link_sdout},   {7'b0, e.sdout});
            check(e.tag, "link_reset_n", {7'b0, link_reset_n}, {7'b0, e.rstn});
            check(e.tag, "rx_mic_sel",   {7'b0, rx_mic_sel},   {7'b0, e.mic});
            check(e.tag, "wake_irq",     {7'b0, wake_irq},     {7'b0, e.irq});
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 reset state",        0, 8'h00, 0, 8'h00, 2'b00, 1, 1, 2'b00);
        step("R7 enable link",        1, 8'h01, 0, 8'h00, 2'b00, 1, 0, 2'b00);
        step("R8 pass-through",       0, 8'h00, 0, 8'h00, 2'b00, 0, 1, 2'b00);
        step("R3 reserved bits",      1, 8'hC0, 0, 8'h00, 2'b00, 1, 1, 2'b00);
        step("R3 zero write",         1, 8'h00, 1, 8'h00, 2'b00, 1, 1, 2'b00);
        step("R8 low-power",          1, 8'h02, 0, 8'h00, 2'b00, 1, 1, 2'b00);
        step("R9 warm over lowpwr",   1, 8'h08, 0, 8'h00, 2'b00, 0, 1, 2'b00);
        step("R9 warm no lowpwr",     0, 8'h00, 1, 8'h02, 2'b00, 0, 1, 2'b00);
        step("R4 clear warm",         0, 8'h00, 1, 8'h08, 2'b00, 0, 1, 2'b00);
        step("R11 mic select",        1, 8'h10, 0, 8'h00, 2'b00, 0, 0, 2'b00);
        step("R10 wake no sdin",      1, 8'h04, 0, 8'h00, 2'b00, 0, 0, 2'b00);
        step("R10 wake sdin1",        0, 8'h00, 0, 8'h00, 2'b00, 0, 0, 2'b10);
        step("R10 wake sdin0",        0, 8'h00, 0, 8'h00, 2'b00, 0, 0, 2'b01);
        step("R4 set/clear same bit", 1, 8'h02, 1, 8'h06, 2'b00, 1, 1, 2'b11);
        step("R2 set all",            1, 8'h1F, 0, 8'h00, 2'b00, 0, 1, 2'b00);
        step("R4 clear all",          0, 8'h00, 1, 8'h3F, 2'b00, 1, 1, 2'b00);
        step("R6 ready pulse 0",      0, 8'h00, 0, 8'h00, 2'b01, 0, 0, 2'b00);
        step("R6 ready pulse 1",      0, 8'h00, 0, 8'h00, 2'b10, 0, 0, 2'b00);
        step("R5 clr bit in disable", 0, 8'h00, 1, 8'h20, 2'b00, 0, 0, 2'b00);
        step("R5 clear ready",        1, 8'h21, 0, 8'h00, 2'b00, 0, 0, 2'b00);
        step("R6 pulse again",        0, 8'h00, 0, 8'h00, 2'b11, 0, 0, 2'b00);
        step("R6 clear beats pulse",  1, 8'h20, 0, 8'h00, 2'b11, 0, 0, 2'b00);
        step("R10 wake off",          0, 8'h00, 1, 8'h04, 2'b00, 0, 0, 2'b11);
        step("R2 hold",               0, 8'h00, 0, 8'h00, 2'b00, 1, 1, 2'b11);
        @(negedge clk);
        set_we = 0; clr_we = 0; ready_pulse = '0;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule